// File: doc/BRIEF.md
# Operand Transfer Engine with Single and Dual Addressing

This block moves one 16-bit operand between memory and a peripheral over a simple synchronous bus on which it is the master. A 2-bit device-type code, captured together with the direction and both addresses when a start pulse is accepted, selects the addressing style. In single-address mode the peripheral is selected by an acknowledge strobe rather than an address. Memory and peripheral then exchange the word directly in one bus cycle. The engine only drives the memory address and the read or write strobe.

In dual-address mode both ends are explicitly addressed. A read cycle at the source address loads an internal holding register. A second cycle then writes that register to the destination address. The direction input picks the source and destination: 1 moves memory to device and 0 moves device to memory. For the acknowledge-and-ready device type, the single cycle is stretched until the peripheral raises ready. A one-clock done pulse marks the end of the operand. Request arbitration and address stepping belong to the surrounding channel logic.

Top module: `xfer_engine`

## Requirements
- R1: While reset is held, and right after it, bus_rd, bus_wr, dev_ack, busy and done are low and bus_wdata is zero.
- R2: Device type 2'b10 (acknowledge, single address) runs exactly one bus cycle with dev_ack high and bus_addr = mem_addr. bus_rd is high when to_dev = 1 and bus_wr is high when to_dev = 0. dev_ready has no effect on this cycle.
- R3: Device type 2'b11 (acknowledge and ready, single address) holds the acknowledged cycle until dev_ready is sampled high on a clock edge, so a cycle that waits N clocks lasts N+1 clocks.
- R4: Device types 2'b00 and 2'b01 (dual address) run a one-clock read at the source address followed by a one-clock write at the destination address. The source is mem_addr when to_dev = 1 and dev_addr when to_dev = 0; the destination is the other address.
- R5: In dual-address mode, the word on bus_rdata during the read cycle is placed in the holding register and driven on bus_wdata during the write cycle.
- R6: In single-address mode the holding register is not loaded, so bus_wdata keeps its value. dev_ack is never asserted in dual-address mode, and bus_rd and bus_wr are never high together.
- R7: done is high for exactly one clock, in the clock that follows the last bus cycle of the operand.
- R8: A start pulse that arrives while a transfer is in progress is ignored. Changes to dev_type, to_dev, mem_addr or dev_addr after a start has been accepted do not affect that transfer.
- R9: busy is high from the clock after an accepted start until the clock in which done is high, and it is low in that clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse for one operand transfer |
| to_dev | input | 1 | Direction: 1 memory to device, 0 device to memory |
| dev_type | input | 2 | Device-type code (addressing style, ready use) |
| mem_addr | input | AW | Memory word address |
| dev_addr | input | AW | Device address, used in dual-address mode |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | DW | Write data, taken from the holding register |
| bus_rdata | input | DW | Read data returned during a read cycle |
| dev_ack | output | 1 | Peripheral acknowledge strobe (single-address mode) |
| dev_ready | input | 1 | Peripheral ready, used by device type 2'b11 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-operand pulse |

## Verification
The bench covers every device-type code with both directions and three address pairs. The patterns tell the two dual-address types apart from the two single-address types by strobe count, addresses and holding-register behaviour. Direction is confirmed by which address is read and which is written. For type 2'b11, wait lengths of 0, 2 and 4 clocks show that the cycle stretches by exactly the wait. For type 2'b10, ready is held low to show that it is not consulted. A second start issued during a dual-address transfer, with the inputs changed after acceptance, shows that in-flight operands are unaffected.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    DT_MEM_DUAL   = 2'b00,
    DT_SYNC_DUAL  = 2'b01,
    DT_ACK_SGL    = 2'b10,
    DT_ACKRDY_SGL = 2'b11
  } dev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SGL,
    ST_RD,
    ST_WR
  } xfer_st_e;

  function automatic logic is_single(input logic [1:0] kind);
    return kind[1];
  endfunction

  function automatic logic needs_ready(input logic [1:0] kind);
    return kind == DT_ACKRDY_SGL;
  endfunction

endpackage

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       to_dev,
  input  logic [1:0] dev_type,
  input  logic       dev_ready,
  output logic       launch,
  output logic       advance,
  output logic       bus_rd,
  output logic       bus_wr,
  output logic       dev_ack,
  output logic       busy,
  output logic       done,
  output logic [1:0] typ_q
);

  xfer_st_e st;

  assign launch  = (st == ST_IDLE) && start;
  assign advance = (st == ST_RD);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bus_rd  <= 1'b0;
      bus_wr  <= 1'b0;
      dev_ack <= 1'b0;
      done    <= 1'b0;
      typ_q   <= 2'b00;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            typ_q <= dev_type;
            if (is_single(dev_type)) begin
              st      <= ST_SGL;
              dev_ack <= 1'b1;
              bus_rd  <= to_dev;
              bus_wr  <= ~to_dev;
            end else begin
              st     <= ST_RD;
              bus_rd <= 1'b1;
            end
          end
        end
        ST_RD: begin
          st     <= ST_WR;
          bus_rd <= 1'b0;
          bus_wr <= 1'b1;
        end
        ST_WR: begin
          st     <= ST_IDLE;
          bus_wr <= 1'b0;
          done   <= 1'b1;
        end
        ST_SGL: begin
          if (!needs_ready(typ_q) || dev_ready) begin
            st      <= ST_IDLE;
            bus_rd  <= 1'b0;
            bus_wr  <= 1'b0;
            dev_ack <= 1'b0;
            done    <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          advance,
  input  logic          single,
  input  logic          to_dev,
  input  logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] dev_addr,
  output logic [AW-1:0] bus_addr
);

  logic [AW-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      dst_q    <= '0;
    end else if (launch) begin
      if (single) begin
        bus_addr <= mem_addr;
      end else begin
        bus_addr <= to_dev ? mem_addr : dev_addr;
      end
      dst_q <= to_dev ? dev_addr : mem_addr;
    end else if (advance) begin
      bus_addr <= dst_q;
    end
  end

endmodule

// File: rtl/xfer_hold.sv
module xfer_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (cap) begin
      q <= din;
    end
  end

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          to_dev,
  input  logic [1:0]    dev_type,
  input  logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] dev_addr,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          dev_ack,
  input  logic          dev_ready,
  output logic          busy,
  output logic          done
);

  logic       launch;
  logic       advance;
  logic [1:0] typ_q;

  xfer_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .to_dev    (to_dev),
    .dev_type  (dev_type),
    .dev_ready (dev_ready),
    .launch    (launch),
    .advance   (advance),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .dev_ack   (dev_ack),
    .busy      (busy),
    .done      (done),
    .typ_q     (typ_q)
  );

  xfer_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .advance  (advance),
    .single   (is_single(dev_type)),
    .to_dev   (to_dev),
    .mem_addr (mem_addr),
    .dev_addr (dev_addr),
    .bus_addr (bus_addr)
  );

  xfer_hold #(.DW(DW)) u_hold (
    .clk (clk),
    .rst (rst),
    .cap (advance),
    .din (bus_rdata),
    .q   (bus_wdata)
  );

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          dev_ack,
  input logic          dev_ready,
  input logic          busy,
  input logic          done,
  input logic [1:0]    typ_q,
  input logic [DW-1:0] bus_wdata
);

  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
    dev_ack |-> typ_q[1]);

  p_hold_kept_r6: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> $stable(bus_wdata));

  p_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    (dev_ack && typ_q == 2'b10) |=> !dev_ack);

  p_wait_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    (dev_ack && typ_q == 2'b11 && !dev_ready) |=> dev_ack);

  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !dev_ack) |=> (bus_wr && !dev_ack));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bus_rd || bus_wr) && !bus_rd && !bus_wr));

  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind xfer_engine xfer_engine_chk #(.DW(DW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .dev_ack   (dev_ack),
  .dev_ready (dev_ready),
  .busy      (busy),
  .done      (done),
  .typ_q     (typ_q),
  .bus_wdata (bus_wdata)
);

// File: tb/test_xfer_engine.sv
`timescale 1ns/1ps
module test_xfer_engine;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          to_dev;
  logic [1:0]    dev_type;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] dev_addr;
  logic [AW-1:0] bus_addr;
  logic          bus_rd;
  logic          bus_wr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          dev_ack;
  logic          dev_ready;
  logic          busy;
  logic          done;

  always #2.5 clk = ~clk;

  xfer_engine #(.AW(AW), .DW(DW)) i_xfer_engine (
    .clk(clk), .rst(rst), .start(start), .to_dev(to_dev), .dev_type(dev_type),
    .mem_addr(mem_addr), .dev_addr(dev_addr), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_ack(dev_ack), .dev_ready(dev_ready),
    .busy(busy), .done(done)
  );

  // Bus model: 32-word space shared by memory and addressed devices
  logic [DW-1:0] space [32];
  logic [DW-1:0] dev_reg;
  logic [DW-1:0] dev_cap;
  logic [AW-1:0] rd_a, wr_a;
  int rd_n, wr_n, ack_n, done_n, ack_run;
  int wait_cfg;
  int n_chk = 0;
  int n_fail = 0;

  assign bus_rdata = space[bus_addr[4:0]];
  assign dev_ready = (ack_run >= wait_cfg);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) space[i] <= 16'hA5A5 ^ (16'(i) * 16'h0103);
      rd_n <= 0; wr_n <= 0; ack_n <= 0; done_n <= 0; ack_run <= 0;
      rd_a <= '0; wr_a <= '0; dev_cap <= '0;
    end else begin
      if (bus_rd) begin
        rd_n <= rd_n + 1;
        rd_a <= bus_addr;
        if (dev_ack) dev_cap <= space[bus_addr[4:0]];
      end
      if (bus_wr) begin
        wr_n <= wr_n + 1;
        wr_a <= bus_addr;
        space[bus_addr[4:0]] <= dev_ack ? dev_reg : bus_wdata;
      end
      if (dev_ack) begin
        ack_n   <= ack_n + 1;
        ack_run <= ack_run + 1;
      end else begin
        ack_run <= 0;
      end
      if (done) done_n <= done_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [1:0] t, input logic d, input logic [AW-1:0] ma,
                      input logic [AW-1:0] da, input int w, output int lat);
    @(negedge clk);
    dev_type = t; to_dev = d; mem_addr = ma; dev_addr = da; wait_cfg = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dev_type = ~t; to_dev = ~d; mem_addr = '1; dev_addr = '1;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int lat, r0, w0, a0, d0;
    logic [AW-1:0] src, dst;
    logic [DW-1:0] sv, wd0;
    rst = 1'b1; start = 1'b0; to_dev = 1'b0; dev_type = 2'b00;
    mem_addr = '0; dev_addr = '0; dev_reg = '0; wait_cfg = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_rd && !bus_wr && !dev_ack, "R1 strobes in reset", {bus_rd, bus_wr, dev_ack}, 0);
    chk(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
    chk(bus_wdata == '0, "R1 wdata in reset", bus_wdata, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !dev_ack && !busy && !done, "R1 after reset",
        {bus_rd, bus_wr, dev_ack, busy, done}, 0);

    for (int t = 0; t < 4; t++) begin
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 3; k++) begin
          logic [AW-1:0] ma, da;
          int w, exp_lat;
          ma = AW'(k * 3 + 1);
          da = AW'(16 + k * 5);
          w  = (t == 3) ? k * 2 : 3;
          src = d[0] ? ma : da;
          dst = d[0] ? da : ma;
          sv  = space[src[4:0]];
          wd0 = bus_wdata;
          dev_reg = 16'h3C00 ^ DW'(t * 64 + d * 8 + k);
          r0 = rd_n; w0 = wr_n; a0 = ack_n; d0 = done_n;
          xfer(2'(t), d[0], ma, da, w, lat);
          @(negedge clk);
          chk(!done, "R7 done lasts one clock", done, 0);
          chk(done_n - d0 == 1, "R7 one done per operand", done_n - d0, 1);
          chk(!busy, "R9 busy low after done", busy, 0);
          if (t < 2) begin
            chk(lat == 3, "R4 dual latency", lat, 3);
            chk(rd_n - r0 == 1 && wr_n - w0 == 1, "R4 one read and one write",
                (rd_n - r0) * 16 + (wr_n - w0), 17);
            chk(ack_n == a0, "R6 no ack in dual mode", ack_n - a0, 0);
            chk(rd_a == src, "R4 read at source", rd_a, src);
            chk(wr_a == dst, "R4 write at destination", wr_a, dst);
            chk(space[dst[4:0]] == sv, "R5 destination holds source word", space[dst[4:0]], sv);
            chk(bus_wdata == sv, "R5 holding register value", bus_wdata, sv);
          end else begin
            exp_lat = (t == 2) ? 2 : w + 2;
            chk(lat == exp_lat, (t == 2) ? "R2 single latency" : "R3 ready-stretched latency",
                lat, exp_lat);
            chk(ack_n - a0 == exp_lat - 1, (t == 2) ? "R2 ack cycles" : "R3 ack cycles",
                ack_n - a0, exp_lat - 1);
            chk(bus_wdata == wd0, "R6 holding register untouched", bus_wdata, wd0);
            if (d == 1) begin
              chk(rd_n - r0 == exp_lat - 1 && wr_n == w0, "R2 memory read strobe",
                  rd_n - r0, exp_lat - 1);
              chk(rd_a == ma, "R2 memory address", rd_a, ma);
              chk(dev_cap == space[ma[4:0]], "R2 device got memory word", dev_cap, space[ma[4:0]]);
            end else begin
              chk(wr_n - w0 == exp_lat - 1 && rd_n == r0, "R2 memory write strobe",
                  wr_n - w0, exp_lat - 1);
              chk(wr_a == ma, "R2 memory address", wr_a, ma);
              chk(space[ma[4:0]] == dev_reg, "R2 memory got device word", space[ma[4:0]], dev_reg);
            end
          end
        end
      end
    end

    // R8: second start while busy is ignored, R9: busy during transfer
    r0 = rd_n; w0 = wr_n; a0 = ack_n; d0 = done_n;
    sv = space[5];
    @(negedge clk);
    dev_type = 2'b00; to_dev = 1'b1; mem_addr = 16'd5; dev_addr = 16'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 busy after start", busy, 1);
    @(negedge clk);
    dev_type = 2'b10; to_dev = 1'b0; mem_addr = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_n - d0 == 1, "R8 only one operand ran", done_n - d0, 1);
    chk(ack_n == a0, "R8 ignored start made no ack", ack_n - a0, 0);
    chk(rd_n - r0 == 1 && wr_n - w0 == 1, "R8 strobe counts", (rd_n - r0) * 16 + (wr_n - w0), 17);
    chk(space[20] == sv, "R8 data moved to latched destination", space[20], sv);
    chk(!busy, "R9 idle afterwards", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule